// File: doc/BRIEF.md
# Global Reset Source Arbiter

This block gathers up to eleven system-level reset requests and decides which of them may trigger a chip-wide reset. Each requester has its own two-bit mode field in a mode register. When an enabled request is seen, the block drives a fixed-length global reset pulse.

The block also records the cause of that reset for each of two processor cores, core A and core B, in a 32-bit sticky cause register. Software reads this register after the system restarts and clears individual flags by writing ones to them. Only the power-on reset input clears the cause register. The global pulse the block drives does not clear it.

Requests are sampled on the rising clock edge and are level sensitive. The block does not synchronise pads and does not sequence power.

Top module: `grst_arbiter`

## Requirements
- R1: The mode register is 22 bits wide and holds one 2-bit field per source. The field for source k occupies bits 2k+1..2k. Source indices are: 0 watchdog 1, 1 watchdog 3, 2 watchdog 4, 3 core B lockup, 4 core A lockup, 5 core B request, 6 core A request, 7 thermal, 8 security unit, 9 debug software reset, 10 over-voltage. Power-on reset sets every field to 3. A write replaces the whole register, takes effect from the next edge and reads back unchanged.
- R2: A source whose field is 0 and whose request is high at a rising edge starts a global reset pulse.
- R3: A source whose field is 1, 2 or 3 neither starts a pulse nor sets any cause flag.
- R4: reset_out rises right after the sampling edge and stays high for exactly GRST_CYCLES cycles (default 16).
- R5: An enabled request sampled while reset_out is high sets its flags but does not lengthen the pulse.
- R6: Core A flags are in bits 0-14, where bit 1 is own request, bit 2 own lockup, bit 3 security unit, bit 5 watchdog 1, bit 7 debug software reset, bit 8 watchdog 3, bit 9 watchdog 4, bit 10 thermal, bit 11 other core request, bit 12 other core lockup and bit 13 over-voltage. For core A, "own" is core A and "other" is core B.
- R7: Core B flags use the same layout at bit offset 16, with "own" meaning core B and "other" meaning core A. A core A request therefore sets bits 1 and 27.
- R8: When several enabled sources are sampled on the same edge, the flags of all of them are set on that edge.
- R9: A clear write removes the flags whose mask bits are 1 and leaves the others. A flag being set on the same edge survives the clear.
- R10: Flags persist through the global pulse and are cleared only by power-on reset. Bits 0, 4, 6, 14, 15, 16, 20, 22, 30 and 31 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| src_req | input | 11 | Reset requests, one bit per source index |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 22 | Mode register write value |
| mode_rdata | output | 22 | Mode register contents |
| clr_we | input | 1 | Cause register clear strobe |
| clr_mask | input | 32 | Write-1-to-clear mask |
| cause_stat | output | 32 | Sticky cause flags |
| reset_out | output | 1 | Global reset pulse, active high |

## Verification
The bench goes after field values 1 and 2. A design that decoded only value 3 as "ignore" would reset the chip on those values.

It also injects a second request in the middle of a pulse. A design that reloaded the counter there would give a pulse longer than GRST_CYCLES. A design that dropped requests during a pulse would lose the flag.

A single core A request checks the own/other swap between the two halves. A wrong mapping puts the flag at bit 11 or bit 17 instead of bit 27.

Finally, a clear is issued on the same edge as a new cause, and the bench checks that status survives a full pulse and is wiped only by power-on reset.

// File: rtl/grst_arb_pkg.sv
package grst_arb_pkg;
   localparam int unsigned MAX_SRC = 11;
   localparam int unsigned MODE_W  = 2;
   localparam int unsigned HALF_W  = 15;
   localparam int unsigned STAT_W  = 32;
   localparam int unsigned B_BASE  = 16;

   typedef enum logic [MODE_W-1:0] {
      MODE_FIRE  = 2'd0,
      MODE_HOLD1 = 2'd1,
      MODE_HOLD2 = 2'd2,
      MODE_MUTE  = 2'd3
   } src_mode_e;

   // position of a source's flag in the core A half
   function automatic int unsigned flag_pos_a(input int unsigned s);
      case (s)
         0:       return 5;
         1:       return 8;
         2:       return 9;
         3:       return 12;
         4:       return 2;
         5:       return 11;
         6:       return 1;
         7:       return 10;
         8:       return 3;
         9:       return 7;
         default: return 13;
      endcase
   endfunction

   // core B sees own/other swapped relative to core A
   function automatic int unsigned mirror_pos(input int unsigned p);
      case (p)
         1:       return 11;
         11:      return 1;
         2:       return 12;
         12:      return 2;
         default: return p;
      endcase
   endfunction

   function automatic logic [STAT_W-1:0] flag_bits(input int unsigned s);
      logic [STAT_W-1:0] v;
      v = '0;
      v[flag_pos_a(s)] = 1'b1;
      v[B_BASE + mirror_pos(flag_pos_a(s))] = 1'b1;
      return v;
   endfunction

   function automatic logic [STAT_W-1:0] live_bits(input int unsigned n);
      logic [STAT_W-1:0] v;
      v = '0;
      for (int unsigned k = 0; k < n; k++) v |= flag_bits(k);
      return v;
   endfunction
endpackage

// File: rtl/grst_mode_bank.sv
module grst_mode_bank
   import grst_arb_pkg::*;
#(
   parameter int unsigned NUM_SRC = 11,
   localparam int unsigned FIELD_BITS = NUM_SRC * MODE_W
) (
   input  logic                  clk,
   input  logic                  por_n,
   input  logic                  wr_en,
   input  logic [FIELD_BITS-1:0] wdata,
   output logic [FIELD_BITS-1:0] rdata,
   input  logic [NUM_SRC-1:0]    req,
   output logic [NUM_SRC-1:0]    hit
);
   for (genvar k = 0; k < NUM_SRC; k++) begin : g_field
      logic [MODE_W-1:0] field_q;

      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)     field_q <= MODE_MUTE;
         else if (wr_en) field_q <= wdata[k*MODE_W +: MODE_W];
      end

      assign rdata[k*MODE_W +: MODE_W] = field_q;
      assign hit[k] = req[k] && (src_mode_e'(field_q) == MODE_FIRE);

      // R3: only a field of 0 lets a request through
      a_r3_hit_only_fire: assert property (@(posedge clk) disable iff (!por_n)
         hit[k] |-> (rdata[k*MODE_W +: MODE_W] == 2'd0));
   end

   // R1: register holds its value when not written
   a_r1_hold: assert property (@(posedge clk) disable iff (!por_n)
      !wr_en |=> $stable(rdata));
   // R1: a write is visible on the next cycle
   a_r1_write: assert property (@(posedge clk) disable iff (!por_n)
      wr_en |=> (rdata == $past(wdata)));
endmodule

// File: rtl/grst_pulse_gen.sv
module grst_pulse_gen #(
   parameter int unsigned GRST_CYCLES = 16,
   localparam int unsigned CNT_W = $clog2(GRST_CYCLES + 1)
) (
   input  logic clk,
   input  logic por_n,
   input  logic trig,
   output logic active
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)              cnt_q <= '0;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
      else if (trig)           cnt_q <= CNT_W'(GRST_CYCLES);
   end

   assign active = (cnt_q != '0);

   // R4: counter never exceeds the configured length
   a_r4_bounded: assert property (@(posedge clk) disable iff (!por_n)
      cnt_q <= CNT_W'(GRST_CYCLES));
   // R5: a running pulse only counts down, never reloads
   a_r5_no_extend: assert property (@(posedge clk) disable iff (!por_n)
      (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
   // R2: a pulse starts only from a sampled trigger
   a_r2_rise_cause: assert property (@(posedge clk) disable iff (!por_n)
      $rose(active) |-> $past(trig));
endmodule

// File: rtl/grst_cause_flags.sv
module grst_cause_flags
   import grst_arb_pkg::*;
#(
   parameter int unsigned NUM_SRC = 11
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic [NUM_SRC-1:0] hit,
   input  logic              clr_en,
   input  logic [STAT_W-1:0] clr_mask,
   output logic [STAT_W-1:0] stat
);
   localparam logic [STAT_W-1:0] LIVE = live_bits(NUM_SRC);

   logic [STAT_W-1:0] set_vec;
   logic [STAT_W-1:0] stat_q;

   always_comb begin
      set_vec = '0;
      for (int unsigned k = 0; k < NUM_SRC; k++)
         if (hit[k]) set_vec |= flag_bits(k);
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~(clr_en ? clr_mask : '0)) | set_vec;
   end

   assign stat = stat_q;

   // R9: masked flags are gone after a clear unless freshly set
   a_r9_clear: assert property (@(posedge clk) disable iff (!por_n)
      clr_en |=> ((stat & $past(clr_mask) & ~$past(set_vec)) == '0));
   // R10: without a clear, no flag ever drops
   a_r10_sticky: assert property (@(posedge clk) disable iff (!por_n)
      !clr_en |=> ((stat & $past(stat)) == $past(stat)));
   // R10: unused positions stay zero
   a_r10_reserved: assert property (@(posedge clk) disable iff (!por_n)
      (stat & ~LIVE) == '0);
endmodule

// File: rtl/grst_arbiter.sv
module grst_arbiter
   import grst_arb_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 11,
   parameter int unsigned GRST_CYCLES = 16,
   localparam int unsigned FIELD_BITS = NUM_SRC * MODE_W
) (
   input  logic                  clk,
   input  logic                  por_n,
   input  logic [NUM_SRC-1:0]    src_req,
   input  logic                  mode_we,
   input  logic [FIELD_BITS-1:0] mode_wdata,
   output logic [FIELD_BITS-1:0] mode_rdata,
   input  logic                  clr_we,
   input  logic [STAT_W-1:0]     clr_mask,
   output logic [STAT_W-1:0]     cause_stat,
   output logic                  reset_out
);
   if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_src
      $error("NUM_SRC must be between 1 and %0d", MAX_SRC);
   end
   if (GRST_CYCLES < 1) begin : g_bad_len
      $error("GRST_CYCLES must be at least 1");
   end

   logic [NUM_SRC-1:0] hit;

   grst_mode_bank #(.NUM_SRC(NUM_SRC)) u_modes (
      .clk   (clk),
      .por_n (por_n),
      .wr_en (mode_we),
      .wdata (mode_wdata),
      .rdata (mode_rdata),
      .req   (src_req),
      .hit   (hit)
   );

   grst_pulse_gen #(.GRST_CYCLES(GRST_CYCLES)) u_pulse (
      .clk    (clk),
      .por_n  (por_n),
      .trig   (|hit),
      .active (reset_out)
   );

   grst_cause_flags #(.NUM_SRC(NUM_SRC)) u_flags (
      .clk      (clk),
      .por_n    (por_n),
      .hit      (hit),
      .clr_en   (clr_we),
      .clr_mask (clr_mask),
      .stat     (cause_stat)
   );

   // R8: any enabled request leaves at least one flag per core behind
   a_r8_flags_follow: assert property (@(posedge clk) disable iff (!por_n)
      (|hit) |=> ((cause_stat[HALF_W-1:0] != '0) && (cause_stat[B_BASE +: HALF_W] != '0)));
endmodule

// File: tb/grst_arbiter_tb.sv
module grst_arbiter_tb;
   localparam int NS = 11;
   localparam int GL = 16;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic [10:0] src_req = '0;
   logic        mode_we = 1'b0;
   logic [21:0] mode_wdata = '0;
   logic [21:0] mode_rdata;
   logic        clr_we = 1'b0;
   logic [31:0] clr_mask = '0;
   logic [31:0] cause_stat;
   logic        reset_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   grst_arbiter #(.NUM_SRC(NS), .GRST_CYCLES(GL)) u_dut (
      .clk(clk), .por_n(por_n), .src_req(src_req), .mode_we(mode_we),
      .mode_wdata(mode_wdata), .mode_rdata(mode_rdata), .clr_we(clr_we),
      .clr_mask(clr_mask), .cause_stat(cause_stat), .reset_out(reset_out)
   );

   // flag position tables, core A and core B
   int pa[NS] = '{5, 8, 9, 12, 2, 11, 1, 10, 3, 7, 13};
   int pb[NS] = '{21, 24, 25, 18, 28, 17, 27, 26, 19, 23, 29};

   // reference model
   int          m_mode[NS];
   int          m_left;
   logic [31:0] m_stat;

   initial begin
      for (int k = 0; k < NS; k++) m_mode[k] = 3;
      m_left = 0;
      m_stat = '0;
   end

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         for (int k = 0; k < NS; k++) m_mode[k] = 3;
         m_left = 0;
         m_stat = '0;
      end else begin
         bit any;
         logic [31:0] nxt;
         any = 0;
         nxt = m_stat;
         if (clr_we) nxt = nxt & ~clr_mask;
         for (int k = 0; k < NS; k++)
            if (src_req[k] && m_mode[k] == 0) begin
               any = 1;
               nxt[pa[k]] = 1'b1;
               nxt[pb[k]] = 1'b1;
            end
         m_stat = nxt;
         if (m_left > 0) m_left = m_left - 1;
         else if (any) m_left = GL;
         if (mode_we)
            for (int k = 0; k < NS; k++) m_mode[k] = int'(mode_wdata[2*k +: 2]);
      end
   end

   function automatic logic [21:0] m_mode_vec();
      logic [21:0] v;
      for (int k = 0; k < NS; k++) v[2*k +: 2] = 2'(m_mode[k]);
      return v;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (!done) begin
         check("R4 reset_out", 32'(reset_out), 32'(m_left > 0));
         check("R6 cause_stat", cause_stat, m_stat);
         check("R1 mode_rdata", 32'(mode_rdata), 32'(m_mode_vec()));
      end
   end

   function automatic logic [21:0] modes_with(input int src, input int val);
      logic [21:0] v;
      v = '1;
      v[2*src +: 2] = 2'(val);
      return v;
   endfunction

   task automatic write_mode(input logic [21:0] v);
      @(posedge clk); #2; mode_we = 1'b1; mode_wdata = v;
      @(posedge clk); #2; mode_we = 1'b0;
   endtask

   task automatic fire(input logic [10:0] m);
      @(posedge clk); #2; src_req = m;
      @(posedge clk); #2; src_req = '0;
   endtask

   task automatic clear(input logic [31:0] m, input logic [10:0] req);
      @(posedge clk); #2; clr_we = 1'b1; clr_mask = m; src_req = req;
      @(posedge clk); #2; clr_we = 1'b0; clr_mask = '0; src_req = '0;
   endtask

   task automatic count_high(output int n);
      n = 0;
      for (int i = 0; i < 3 * GL; i++) begin
         @(negedge clk);
         if (reset_out) n++;
         else break;
      end
   endtask

   task automatic settle();
      repeat (GL + 3) @(posedge clk);
      #2;
   endtask

   task automatic finish_run();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      int n;
      logic [21:0] v;
      repeat (3) @(posedge clk);
      #2; por_n = 1'b1;
      @(negedge clk);
      check("R1 reset mode", 32'(mode_rdata), 32'h3FFFFF);
      check("R10 reset status", cause_stat, 32'h0);
      check("R4 reset pulse idle", 32'(reset_out), 32'h0);

      // R3: all muted, every source fires
      fire(11'h7FF);
      @(negedge clk);
      check("R3 muted no pulse", 32'(reset_out), 32'h0);
      check("R3 muted no flag", cause_stat, 32'h0);

      // R3: field values 1 and 2 also ignore
      write_mode(modes_with(0, 1));
      fire(11'h001);
      @(negedge clk);
      check("R3 mode1 no pulse", 32'(reset_out), 32'h0);
      write_mode(modes_with(0, 2));
      fire(11'h001);
      @(negedge clk);
      check("R3 mode2 no pulse", 32'(reset_out), 32'h0);
      check("R3 mode2 no flag", cause_stat, 32'h0);

      // R2/R4: enabled watchdog 1 fires one full pulse
      write_mode(modes_with(0, 0));
      check("R1 readback", 32'(mode_rdata), 32'(modes_with(0, 0)));
      fire(11'h001);
      count_high(n);
      check("R2 R4 pulse length", 32'(n), 32'(GL));
      check("R6 wdog1 flags", cause_stat, 32'h0020_0020);

      // R5: request inside a running pulse
      v = modes_with(0, 0);
      v[2*7 +: 2] = 2'd0;
      write_mode(v);
      settle();
      fire(11'h001);
      repeat (5) @(posedge clk);
      fire(11'h080);
      count_high(n);
      check("R5 no extension", 32'(n), 32'(GL - 7));
      check("R5 thermal recorded", cause_stat, 32'h0420_0420);

      // R10: status kept through pulse; R9 partial clear
      settle();
      clear(32'h0000_0400, '0);
      @(negedge clk);
      check("R9 partial clear", cause_stat, 32'h0420_0020);
      clear('1, '0);
      @(negedge clk);
      check("R9 full clear", cause_stat, 32'h0);

      // R7: core A request mirrors to bit 27
      write_mode(modes_with(6, 0));
      fire(11'h040);
      settle();
      check("R7 coreA req", cause_stat, 32'h0800_0002);
      clear('1, '0);
      write_mode(modes_with(4, 0));
      fire(11'h010);
      settle();
      check("R7 coreA lockup", cause_stat, 32'h1000_0004);

      // R9: set wins over a same-edge clear
      clear(32'h1000_0004, 11'h010);
      @(negedge clk);
      check("R9 set beats clear", cause_stat, 32'h1000_0004);
      settle();
      clear('1, '0);

      // R8: every source together
      write_mode(22'h0);
      fire(11'h7FF);
      count_high(n);
      check("R8 single pulse", 32'(n), 32'(GL));
      check("R8 all flags", cause_stat, 32'h3FAE_3FAE);
      check("R10 reserved zero", cause_stat & 32'hC051_C051, 32'h0);

      // R10: only power-on reset clears flags
      settle();
      @(posedge clk); #2; por_n = 1'b0;
      @(posedge clk); #2; por_n = 1'b1;
      @(negedge clk);
      check("R10 por clears", cause_stat, 32'h0);
      check("R1 por restores mode", 32'(mode_rdata), 32'h3FFFFF);

      repeat (2) @(posedge clk);
      finish_run();
   end
endmodule